// File: doc/BRIEF.md
# Odd-Address Splitting Bus Sequencer for a Two-Lane 16-Bit Memory Bus

This block sits between a processor core and an external memory bus. The bus is 16 bits wide and made of two byte lanes, each with its own active-low enable. The core hands over one request at a time. A request holds a byte address, a size flag (byte or word), a direction flag and 16 bits of write data. The sequencer turns it into one or two bus cycles, each one clock long. It drives the bus word address, the lane enables, the write strobe and the write data. It gathers the returned bytes into a result register and pulses a completion flag.

A word at an even address is moved in a single 16-bit cycle. A byte uses only the lane that matches the parity of its address. A word at an odd address straddles two bus words, so the block issues two byte cycles in a fixed order. The first cycle uses the high lane and carries the word's low-order byte. The second cycle uses the low lane at the next word address and carries the high-order byte. Internal steering moves each byte between its bus lane and the correct half of the core's data.

Top module: `odd_split_bus_seq`

## Requirements
- R1: After reset the block is idle with `req_ready`=1, `bus_be_n`=2'b11, `bus_we`=0 and `done`=0.
- R2: A byte request at an even address gives exactly one bus cycle with `bus_be_n`=2'b10 (bit 1 is the high-lane enable, bit 0 the low-lane enable, 0 = active). Write data goes on bits 7..0, and a read returns bus bits 7..0 in `rdata[7:0]` with `rdata[15:8]`=0.
- R3: A byte request at an odd address gives exactly one bus cycle with `bus_be_n`=2'b01. Write byte `req_wdata[7:0]` goes on bus bits 15..8. A read moves bus bits 15..8 into `rdata[7:0]` and sets `rdata[15:8]`=0.
- R4: A word request at an even address gives exactly one bus cycle with `bus_be_n`=2'b00, the full 16 bits passed unchanged in both directions.
- R5: A word request at an odd address A gives two cycles. First: `bus_be_n`=2'b01 with byte A (`req_wdata[7:0]`, or `rdata[7:0]` on a read) on bits 15..8. Second: `bus_be_n`=2'b10 with byte A+1 (`req_wdata[15:8]`, or `rdata[15:8]`) on bits 7..0.
- R6: `bus_addr` equals byte address bits ADDR_W-1..1 in a single cycle and in the first cycle of a split. In the second cycle of a split it is one higher, wrapping to 0 past the top.
- R7: `done` is high for exactly one clock, in the cycle after the final bus cycle. A read loads `rdata` on that same edge. `rdata` holds its value while `done` is low, and a write leaves it unchanged.
- R8: `req_valid` is taken only while `req_ready`=1. While busy, a request has no effect on the bus cycles, the data or the memory.
- R9: `bus_we` is 1 only during bus cycles of a write. The bits of a disabled lane on `bus_wdata` are 0, and `bus_wdata` is 0 outside write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, low-order byte in bits 7..0 |
| req_ready | output | 1 | Idle, able to take a request |
| bus_addr | output | ADDR_W-1 | Bus word address |
| bus_be_n | output | 2 | Lane enables, active low, bit 1 high lane |
| bus_we | output | 1 | Write strobe for the current bus cycle |
| bus_wdata | output | 16 | Write data on the two lanes |
| bus_rdata | input | 16 | Read data from the two lanes, sampled at the end of each cycle |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read result |

## Verification
A request taken at a clock edge shows its first bus cycle right after that edge. An aligned access or a byte completes one edge later, with `done` and `rdata` updated together. A misaligned word shows its second bus cycle one edge after the first and completes one edge after that. The bench keeps a behavioural model that advances on the same edges and compares every output at the falling edge. Each compare therefore sees a stable value for the right bus phase. A second request is held high during each busy cycle, and every access is read back against a byte-wise golden memory.

// File: rtl/osb_pkg.sv
package osb_pkg;
  localparam int LANE_W = 8;
  localparam int BUS_W  = 2 * LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } osb_state_e;

  // lane enables (active low, bit1 = high lane) for one bus cycle
  function automatic logic [1:0] lane_enables(input logic is_word, input logic odd,
                                              input logic second);
    if (!is_word)   return odd ? 2'b01 : 2'b10;
    else if (!odd)  return 2'b00;
    else            return second ? 2'b10 : 2'b01;
  endfunction

  // place write bytes onto the enabled lanes, zero elsewhere
  function automatic logic [BUS_W-1:0] place_write(input logic [1:0] be_n,
                                                   input logic [BUS_W-1:0] wd,
                                                   input logic second);
    logic [LANE_W-1:0] pick;
    pick = second ? wd[BUS_W-1:LANE_W] : wd[LANE_W-1:0];
    case (be_n)
      2'b00:   return wd;
      2'b01:   return {pick, {LANE_W{1'b0}}};
      2'b10:   return {{LANE_W{1'b0}}, pick};
      default: return '0;
    endcase
  endfunction

  // pull the single enabled byte out of the bus
  function automatic logic [LANE_W-1:0] pick_lane(input logic [1:0] be_n,
                                                  input logic [BUS_W-1:0] rd);
    return (be_n == 2'b01) ? rd[BUS_W-1:LANE_W] : rd[LANE_W-1:0];
  endfunction

  // assemble the core-side read result at the final bus cycle
  function automatic logic [BUS_W-1:0] assemble_read(input logic is_word, input logic odd,
                                                     input logic [1:0] be_n,
                                                     input logic [BUS_W-1:0] rd,
                                                     input logic [LANE_W-1:0] kept);
    if (is_word && !odd) return rd;
    if (is_word)         return {pick_lane(be_n, rd), kept};
    return {{LANE_W{1'b0}}, pick_lane(be_n, rd)};
  endfunction
endpackage

// File: rtl/osb_ctrl.sv
module osb_ctrl
  import osb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_wdata,
  output osb_state_e        st,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_word,
  output logic              q_write,
  output logic [BUS_W-1:0]  q_wdata,
  output logic              final_cyc,
  output logic              done
);
  logic split;
  logic accept;

  assign split     = q_word & q_addr[0];
  assign accept    = (st == ST_IDLE) & req_valid;
  assign final_cyc = ((st == ST_FIRST) & ~split) | (st == ST_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      done    <= 1'b0;
      q_addr  <= '0;
      q_word  <= 1'b0;
      q_write <= 1'b0;
      q_wdata <= '0;
    end else begin
      done <= final_cyc;
      case (st)
        ST_IDLE: if (accept) begin
          q_addr  <= req_addr;
          q_word  <= req_word;
          q_write <= req_write;
          q_wdata <= req_wdata;
          st      <= ST_FIRST;
        end
        ST_FIRST:  st <= split ? ST_SECOND : ST_IDLE;
        ST_SECOND: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  // R7: completion flag never lasts two clocks
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: the second cycle is only ever reached from the first
  p_second_after_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SECOND) |-> ($past(st) == ST_FIRST));
  // R8: a latched request is not disturbed while busy
  p_busy_holds_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> ($stable(q_addr) && $stable(q_wdata) && $stable(q_word)));
endmodule

// File: rtl/osb_steer.sv
module osb_steer
  import osb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  osb_state_e        st,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              q_word,
  input  logic              q_write,
  input  logic [BUS_W-1:0]  q_wdata,
  output logic [ADDR_W-2:0] bus_addr,
  output logic [1:0]        bus_be_n,
  output logic              bus_we,
  output logic [BUS_W-1:0]  bus_wdata
);
  localparam int WA_W = ADDR_W - 1;

  logic active;
  logic second;

  assign active    = (st != ST_IDLE);
  assign second    = (st == ST_SECOND);
  assign bus_be_n  = active ? lane_enables(q_word, q_addr[0], second) : 2'b11;
  assign bus_addr  = q_addr[ADDR_W-1:1] + {{(WA_W-1){1'b0}}, second};
  assign bus_we    = active & q_write;
  assign bus_wdata = bus_we ? place_write(bus_be_n, q_wdata, second) : '0;

  // R6: second cycle of a split moves to the next bus word
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SECOND) |-> (bus_addr == $past(bus_addr) + 1'b1));
  // R5: split order is high lane first, then low lane
  p_lane_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SECOND) |-> (bus_be_n == 2'b10 && $past(bus_be_n) == 2'b01));
  // R1: no lane enabled and no strobe while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (bus_be_n == 2'b11 && !bus_we));
  // R9: the disabled lane carries zeros during a low-lane write
  p_unused_lane_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_be_n == 2'b10) |-> (bus_wdata[BUS_W-1:LANE_W] == '0));
endmodule

// File: rtl/osb_gather.sv
module osb_gather
  import osb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  osb_state_e       st,
  input  logic             q_odd,
  input  logic             q_word,
  input  logic             q_write,
  input  logic             final_cyc,
  input  logic [1:0]       bus_be_n,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic [BUS_W-1:0] rdata
);
  logic [LANE_W-1:0] kept_lo;
  logic              keep_now;
  logic              load_now;

  assign keep_now = (st == ST_FIRST) & q_word & q_odd & ~q_write;
  assign load_now = final_cyc & ~q_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kept_lo <= '0;
      rdata   <= '0;
    end else begin
      if (keep_now) kept_lo <= pick_lane(bus_be_n, bus_rdata);
      if (load_now) rdata   <= assemble_read(q_word, q_odd, bus_be_n, bus_rdata, kept_lo);
    end
  end

  // R3: a byte read leaves the upper result half cleared
  p_byte_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !q_word) |=> (rdata[BUS_W-1:LANE_W] == '0));
endmodule

// File: rtl/odd_split_bus_seq.sv
module odd_split_bus_seq
  import osb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic              req_ready,
  output logic [ADDR_W-2:0] bus_addr,
  output logic [1:0]        bus_be_n,
  output logic              bus_we,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  output logic              done,
  output logic [15:0]       rdata
);
  osb_state_e        st;
  logic [ADDR_W-1:0] q_addr;
  logic              q_word;
  logic              q_write;
  logic [BUS_W-1:0]  q_wdata;
  logic              final_cyc;

  assign req_ready = (st == ST_IDLE);

  osb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
    .st(st), .q_addr(q_addr), .q_word(q_word), .q_write(q_write),
    .q_wdata(q_wdata), .final_cyc(final_cyc), .done(done)
  );

  osb_steer #(.ADDR_W(ADDR_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .st(st), .q_addr(q_addr), .q_word(q_word),
    .q_write(q_write), .q_wdata(q_wdata), .bus_addr(bus_addr),
    .bus_be_n(bus_be_n), .bus_we(bus_we), .bus_wdata(bus_wdata)
  );

  osb_gather u_gather (
    .clk(clk), .rst_n(rst_n), .st(st), .q_odd(q_addr[0]), .q_word(q_word),
    .q_write(q_write), .final_cyc(final_cyc), .bus_be_n(bus_be_n),
    .bus_rdata(bus_rdata), .rdata(rdata)
  );

  // R7: result register only moves on the edge that raises done
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));
  // R8: no new request is taken while busy
  p_ready_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready) |-> (bus_be_n != 2'b11));
endmodule

// File: tb/test_odd_split_bus_seq.sv
module test_odd_split_bus_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NBYTES = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_word = 1'b0;
  logic req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic req_ready;
  logic [AW-2:0] bus_addr;
  logic [1:0] bus_be_n;
  logic bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic done;
  logic [15:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  odd_split_bus_seq #(.ADDR_W(AW)) i_odd_split_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
    .req_ready(req_ready), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .rdata(rdata)
  );

  // two-lane memory on the bus side, byte-wise golden memory on the model side
  logic [7:0] mem_lo [NBYTES/2];
  logic [7:0] mem_hi [NBYTES/2];
  logic [7:0] gold [NBYTES];
  assign bus_rdata = {mem_hi[bus_addr], mem_lo[bus_addr]};

  always @(posedge clk) begin
    if (rst_n && bus_we) begin
      if (!bus_be_n[0]) mem_lo[bus_addr] <= bus_wdata[7:0];
      if (!bus_be_n[1]) mem_hi[bus_addr] <= bus_wdata[15:8];
    end
  end

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_phase = 0;
  int m_addr = 0;
  bit m_word = 0, m_wr = 0;
  int m_wd = 0;
  bit exp_done = 0;
  int exp_rdata = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; exp_done = 0; exp_rdata = 0;
    end else begin
      exp_done = 0;
      if (m_phase == 0) begin
        if (req_valid) begin
          m_addr = req_addr; m_word = req_word; m_wr = req_write; m_wd = req_wdata;
          m_phase = 1;
        end
      end else if (m_phase == 1 && m_word && m_addr[0]) begin
        m_phase = 2;
      end else begin
        m_phase = 0;
        exp_done = 1;
        if (m_wr) begin
          gold[m_addr] = m_wd[7:0];
          if (m_word) gold[(m_addr + 1) % NBYTES] = m_wd[15:8];
        end else if (m_word) begin
          exp_rdata = {gold[(m_addr + 1) % NBYTES], gold[m_addr]};
        end else begin
          exp_rdata = {8'h00, gold[m_addr]};
        end
      end
    end
  end

  function automatic string kind_tag();
    if (!m_word) return m_addr[0] ? "R3" : "R2";
    return m_addr[0] ? "R5" : "R4";
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 be_n", bus_be_n, 2'b11);
      chk("R1 done", done, 0);
      chk("R1 ready", req_ready, 1);
      chk("R1 we", bus_we, 0);
    end else begin
      int e_be, e_addr, e_wd;
      chk("R8 ready", req_ready, m_phase == 0);
      chk("R7 done", done, exp_done);
      chk("R7 rdata", rdata, exp_rdata);
      if (m_phase == 0) begin
        chk("R1 idle be_n", bus_be_n, 2'b11);
        chk("R9 idle we", bus_we, 0);
        chk("R9 idle wdata", bus_wdata, 0);
      end else begin
        e_addr = m_addr >> 1;
        if (!m_word) begin
          e_be = m_addr[0] ? 2'b01 : 2'b10;
          e_wd = m_addr[0] ? {m_wd[7:0], 8'h00} : {8'h00, m_wd[7:0]};
        end else if (!m_addr[0]) begin
          e_be = 2'b00; e_wd = m_wd[15:0];
        end else if (m_phase == 1) begin
          e_be = 2'b01; e_wd = {m_wd[7:0], 8'h00};
        end else begin
          e_be = 2'b10; e_wd = {8'h00, m_wd[15:8]};
          e_addr = (e_addr + 1) % (NBYTES/2);
        end
        chk({kind_tag(), " be_n"}, bus_be_n, e_be);
        chk("R6 addr", bus_addr, e_addr);
        chk("R9 we", bus_we, m_wr);
        chk({kind_tag(), " R9 wdata"}, bus_wdata, m_wr ? e_wd : 0);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      summary();
    end
  end

  // one request, then a busy-time request that must be ignored (R8)
  task automatic issue(input int a, input bit w, input bit wr, input int d);
    @(negedge clk);
    req_valid = 1; req_addr = a[AW-1:0]; req_word = w; req_write = wr; req_wdata = d[15:0];
    @(negedge clk);
    req_addr = req_addr ^ 8'h55; req_wdata = ~req_wdata; req_word = ~w; req_write = ~wr;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int lfsr;
    for (int i = 0; i < NBYTES; i++) gold[i] = 8'(i * 7 + 3);
    for (int i = 0; i < NBYTES/2; i++) begin
      mem_lo[i] = 8'((2*i) * 7 + 3);
      mem_hi[i] = 8'((2*i+1) * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // directed: R2, R3, R4, R5 writes and reads, wrap at top for R6
    issue(8'h10, 1, 1, 16'hA1B2);
    issue(8'h21, 0, 1, 16'h005C);
    issue(8'h20, 0, 1, 16'h003D);
    issue(8'h31, 1, 1, 16'h1234);
    issue(8'hFF, 1, 1, 16'hBEEF);
    issue(8'h10, 1, 0, 0);
    issue(8'h20, 1, 0, 0);
    issue(8'h11, 0, 0, 0);
    issue(8'h20, 0, 0, 0);
    issue(8'h31, 1, 0, 0);
    issue(8'h11, 1, 0, 0);
    issue(8'hFF, 1, 0, 0);
    issue(8'h00, 0, 0, 0);
    // mixed pseudo-random traffic
    lfsr = 32'h1ACE;
    for (int k = 0; k < 60; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      issue(lfsr & 8'hFF, lfsr[9], lfsr[10], (lfsr * 40503) & 16'hFFFF);
    end
    summary();
  end
endmodule